// File: doc/BRIEF.md
# Processor Performance Monitor Counter Unit

This block counts processor activity for profiling. It has one 32-bit cycle counter and three 32-bit event counters. Software programs it over a simple register bus: a write strobe, a read strobe, a 3-bit word address, write data and read data. Read data is combinational and is valid in the same cycle as the read strobe. When no read is in progress it is zero.

Each event counter is bound to a 7-bit event code and adds one in every cycle in which the selected line of a 128-bit event pulse vector is high. Two codes are special. Code 0x11 counts every clock. Code 0x00 counts software increments made through a dedicated register. The event counters share a single pair of indirect registers, and a select register chooses which counter they reach. The cycle counter can be slowed by a divide-by-64 prescaler.

Top module: `perf_mon_unit`

## Requirements
- R1: While the global run bit (bit 0 of the control register, address 0) is 0, neither the cycle counter nor any event counter advances.
- R2: Writing 1 to control bit 1 clears all three event counters. Writing 1 to control bit 2 clears the cycle counter and its prescaler. Neither bit is stored, so both always read back as 0.
- R3: When control bit 3 is 1, the cycle counter advances once per 64 enabled clocks. The prescaler starts from zero after a cycle-counter clear.
- R4: Writing to enable-set (address 1) sets the mask bits written as 1. Writing to enable-clear (address 2) clears them. A read of either address returns the mask. Bit 31 enables the cycle counter, and bits 0 to 2 enable event counters 0 to 2. A counter whose mask bit is 0 holds its value.
- R5: The select register (address 3) reads back the value written to it. The event-type register (address 4, bits 6:0) and the counter-value register (address 5) access the event counter whose index is held in the select register.
- R6: When the select value is 3 or more, reads of addresses 4 and 5 return 0 and writes to them change no counter and no code.
- R7: Address 6 reads the cycle counter. Writing 0 to it clears the counter and the prescaler. A non-zero write has no effect.
- R8: An event counter whose code is neither 0x00 nor 0x11 adds 1 in each enabled cycle in which the event-vector bit at index equal to its code is high. It ignores every other bit of the vector.
- R9: An event counter with code 0x11 adds 1 on every enabled clock, regardless of the event vector.
- R10: A write to address 7 adds 1 to each event counter j for which data bit j is 1, provided that counter has code 0x00, its mask bit is set and the global run bit is 1.
- R11: Counters wrap from 0xFFFFFFFF to 0 and raise no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, zero when no read |
| evt_i | input | 128 | Event pulse vector indexed by event code |

## Verification
The checker evaluates the following on every cycle:
- Both counter kinds hold while the global run bit is 0.
- The cycle counter moves by at most one per cycle when there is no bus write, which includes the wrap.
- A zero write to the cycle-value register clears that register.
- The control reset bits read back as 0.
- Indirect reads return zero when the selected counter index is out of range.

Only the bench's scenarios show the following:
- The exact counts for each event code over the whole code space.
- The divide-by-64 rate and the clearing of the prescaler.
- The masking of software increments.
- The event-counter wrap.

// File: rtl/perf_mon_pkg.sv
package perf_mon_pkg;

  typedef enum logic [2:0] {
    ADDR_CTRL   = 3'd0,
    ADDR_EN_SET = 3'd1,
    ADDR_EN_CLR = 3'd2,
    ADDR_SEL    = 3'd3,
    ADDR_TYPE   = 3'd4,
    ADDR_VAL    = 3'd5,
    ADDR_CYC    = 3'd6,
    ADDR_SWINC  = 3'd7
  } reg_addr_e;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_EVCL_BIT = 1;
  localparam int CTRL_CYCL_BIT = 2;
  localparam int CTRL_DIV_BIT  = 3;
  localparam int CYC_EN_BIT    = 31;

  localparam int CODE_SWINC  = 'h00;
  localparam int CODE_CYCLES = 'h11;

endpackage

// File: rtl/perf_cycle_ctr.sv
module perf_cycle_ctr #(
  parameter int CNT_W   = 32,
  parameter int PRESC_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             div_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [PRESC_W-1:0] presc_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               tick;

  assign tick  = !div_i || (&presc_q);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= '0;
      cnt_q   <= '0;
    end else if (clr_i) begin
      presc_q <= '0;
      cnt_q   <= '0;
    end else if (run_i) begin
      if (div_i) presc_q <= presc_q + PRESC_W'(1);
      if (tick)  cnt_q   <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/perf_evt_ctr.sv
module perf_evt_ctr #(
  parameter int CNT_W  = 32,
  parameter int CODE_W = 7,
  localparam int EVT_N = 2 ** CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              clr_i,
  input  logic              type_we_i,
  input  logic              val_we_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic              sw_inc_i,
  input  logic [EVT_N-1:0]  evt_i,
  output logic [CODE_W-1:0] code_o,
  output logic [CNT_W-1:0]  cnt_o
);
  import perf_mon_pkg::*;

  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              hit;

  always_comb begin
    if (code_q == CODE_W'(CODE_SWINC))       hit = sw_inc_i;
    else if (code_q == CODE_W'(CODE_CYCLES)) hit = 1'b1;
    else                                     hit = evt_i[code_q];
  end

  assign code_o = code_q;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        code_q <= '0;
    else if (type_we_i) code_q <= wdata_i[CODE_W-1:0];
  end

  // clear beats a direct write, which beats counting
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (val_we_i)       cnt_q <= wdata_i;
    else if (run_i && hit)   cnt_q <= cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit #(
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 3,
  parameter int CODE_W  = 7,
  parameter int SEL_W   = 4,
  parameter int PRESC_W = 6,
  localparam int EVT_N  = 2 ** CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [2:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [EVT_N-1:0]  evt_i
);
  import perf_mon_pkg::*;

  logic                            glob_en_q;
  logic                            div_q;
  logic                            cyc_en_q;
  logic [NUM_EVT-1:0]              evt_en_q;
  logic [SEL_W-1:0]                sel_q;
  logic [CNT_W-1:0]                cyc_cnt;
  logic [NUM_EVT-1:0][CNT_W-1:0]   evt_cnt;
  logic [NUM_EVT-1:0][CODE_W-1:0]  evt_code;
  logic [NUM_EVT-1:0]              type_we, val_we, sw_inc;
  logic                            we_ctrl, we_set, we_clr, we_sel, we_cyc, we_inc;
  logic                            evt_clr, cyc_clr;
  logic [31:0]                     mask_rd, sel_type_rd, sel_val_rd;

  assign we_ctrl = wr_en_i && (addr_i == ADDR_CTRL);
  assign we_set  = wr_en_i && (addr_i == ADDR_EN_SET);
  assign we_clr  = wr_en_i && (addr_i == ADDR_EN_CLR);
  assign we_sel  = wr_en_i && (addr_i == ADDR_SEL);
  assign we_cyc  = wr_en_i && (addr_i == ADDR_CYC);
  assign we_inc  = wr_en_i && (addr_i == ADDR_SWINC);

  assign evt_clr = we_ctrl && wdata_i[CTRL_EVCL_BIT];
  assign cyc_clr = (we_ctrl && wdata_i[CTRL_CYCL_BIT]) || (we_cyc && (wdata_i == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glob_en_q <= 1'b0;
      div_q     <= 1'b0;
      cyc_en_q  <= 1'b0;
      evt_en_q  <= '0;
      sel_q     <= '0;
    end else begin
      if (we_ctrl) begin
        glob_en_q <= wdata_i[CTRL_RUN_BIT];
        div_q     <= wdata_i[CTRL_DIV_BIT];
      end
      if (we_set) begin
        cyc_en_q <= cyc_en_q | wdata_i[CYC_EN_BIT];
        evt_en_q <= evt_en_q | wdata_i[NUM_EVT-1:0];
      end
      if (we_clr) begin
        cyc_en_q <= cyc_en_q & ~wdata_i[CYC_EN_BIT];
        evt_en_q <= evt_en_q & ~wdata_i[NUM_EVT-1:0];
      end
      if (we_sel) sel_q <= wdata_i[SEL_W-1:0];
    end
  end

  perf_cycle_ctr #(.CNT_W(CNT_W), .PRESC_W(PRESC_W)) u_cyc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (glob_en_q && cyc_en_q),
    .div_i  (div_q),
    .clr_i  (cyc_clr),
    .cnt_o  (cyc_cnt)
  );

  for (genvar j = 0; j < NUM_EVT; j++) begin : g_evt
    assign type_we[j] = wr_en_i && (addr_i == ADDR_TYPE) && (sel_q == SEL_W'(j));
    assign val_we[j]  = wr_en_i && (addr_i == ADDR_VAL)  && (sel_q == SEL_W'(j));
    assign sw_inc[j]  = we_inc && wdata_i[j];

    perf_evt_ctr #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_evt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (glob_en_q && evt_en_q[j]),
      .clr_i     (evt_clr),
      .type_we_i (type_we[j]),
      .val_we_i  (val_we[j]),
      .wdata_i   (wdata_i[CNT_W-1:0]),
      .sw_inc_i  (sw_inc[j]),
      .evt_i     (evt_i),
      .code_o    (evt_code[j]),
      .cnt_o     (evt_cnt[j])
    );
  end

  always_comb begin
    mask_rd = '0;
    mask_rd[CYC_EN_BIT]    = cyc_en_q;
    mask_rd[NUM_EVT-1:0]   = evt_en_q;
    sel_type_rd = '0;
    sel_val_rd  = '0;
    for (int j = 0; j < NUM_EVT; j++) begin
      if (sel_q == SEL_W'(j)) begin
        sel_type_rd = 32'(evt_code[j]);
        sel_val_rd  = 32'(evt_cnt[j]);
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      case (addr_i)
        ADDR_CTRL: begin
          rdata_o[CTRL_RUN_BIT] = glob_en_q;
          rdata_o[CTRL_DIV_BIT] = div_q;
        end
        ADDR_EN_SET, ADDR_EN_CLR: rdata_o = mask_rd;
        ADDR_SEL:                 rdata_o = 32'(sel_q);
        ADDR_TYPE:                rdata_o = sel_type_rd;
        ADDR_VAL:                 rdata_o = sel_val_rd;
        ADDR_CYC:                 rdata_o = 32'(cyc_cnt);
        default:                  rdata_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/perf_mon_unit_chk.sv
module perf_mon_unit_chk #(
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 3,
  parameter int SEL_W   = 4
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          wr_en_i,
  input logic                          rd_en_i,
  input logic [2:0]                    addr_i,
  input logic [31:0]                   wdata_i,
  input logic [31:0]                   rdata_o,
  input logic                          glob_en_i,
  input logic [SEL_W-1:0]              sel_i,
  input logic [CNT_W-1:0]              cyc_cnt_i,
  input logic [NUM_EVT-1:0][CNT_W-1:0] evt_cnt_i
);

  AST_CYC_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!glob_en_i && !wr_en_i) |=> $stable(cyc_cnt_i)); // R1

  AST_EVT_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!glob_en_i && !wr_en_i) |=> $stable(evt_cnt_i)); // R1

  AST_CTRL_PULSE_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 3'd0) |-> (rdata_o[2:1] == 2'b00)); // R2

  AST_BAD_SEL_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (addr_i == 3'd4 || addr_i == 3'd5) && sel_i >= SEL_W'(NUM_EVT))
      |-> (rdata_o == 32'd0)); // R6

  AST_CYC_ZERO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'd6 && wdata_i == 32'd0) |=> (cyc_cnt_i == '0)); // R7

  AST_CYC_UNIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (cyc_cnt_i == $past(cyc_cnt_i) ||
                  cyc_cnt_i == $past(cyc_cnt_i) + CNT_W'(1))); // R11

endmodule

bind perf_mon_unit perf_mon_unit_chk #(
  .CNT_W(CNT_W), .NUM_EVT(NUM_EVT), .SEL_W(SEL_W)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .rd_en_i   (rd_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .glob_en_i (glob_en_q),
  .sel_i     (sel_q),
  .cyc_cnt_i (cyc_cnt),
  .evt_cnt_i (evt_cnt)
);

// File: tb/perf_mon_unit_tb_top.sv
module perf_mon_unit_tb_top;

  localparam logic [2:0] A_CTRL = 3'd0, A_SET = 3'd1, A_CLR = 3'd2, A_SEL = 3'd3,
                         A_TYPE = 3'd4, A_VAL = 3'd5, A_CYC = 3'd6, A_INC = 3'd7;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [127:0] evt = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  perf_mon_unit dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .wr_en_i (wr_en),
    .rd_en_i (rd_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .evt_i   (evt)
  );

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 v = rdata;
    rd_en = 1'b0;
    n_chk++;
    if (v !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%0d actual=0x%08h expected=0x%08h", req, a, v, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    int n;
    logic [31:0] m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd_chk("R1 reset ctrl", A_CTRL, 0);
    rd_chk("R4 reset mask", A_SET, 0);
    rd_chk("R5 reset sel", A_SEL, 0);
    rd_chk("R7 reset cyc", A_CYC, 0);
    rd_chk("R5 reset val", A_VAL, 0);

    // R1: everything armed but global run off
    wr(A_SET, 32'h8000_0007);
    wr(A_SEL, 0); wr(A_TYPE, 32'h11);
    wr(A_SEL, 1); wr(A_TYPE, 32'h05);
    evt[5] = 1'b1;
    idle(20);
    evt = '0;
    rd_chk("R1 cyc held", A_CYC, 0);
    rd_chk("R1 evt1 held", A_VAL, 0);
    wr(A_SEL, 0);
    rd_chk("R1 evt0 held", A_VAL, 0);

    // R4: set/clear sweep over implemented mask bits
    foreach (m[b]) begin
      if (b == 0 || b == 1 || b == 2 || b == 31) begin
        wr(A_CLR, 32'(1) << b);
        rd_chk("R4 clr via set addr", A_SET, 32'h8000_0007 & ~(32'(1) << b));
        rd_chk("R4 clr via clr addr", A_CLR, 32'h8000_0007 & ~(32'(1) << b));
        wr(A_SET, 32'(1) << b);
        rd_chk("R4 set restore", A_SET, 32'h8000_0007);
      end
    end

    // R8: sweep all ordinary event codes
    for (int c = 1; c < 128; c++) begin
      if (c != 'h11) begin
        int k;
        k = (c % 5) + 1;
        wr(A_SEL, c % 3);
        wr(A_TYPE, c);
        wr(A_VAL, 0);
        wr(A_CTRL, 1);
        for (int i = 0; i < k; i++) begin
          evt = '0; evt[c] = 1'b1;
          @(negedge clk);
        end
        evt = '1; evt[c] = 1'b0;
        idle(3);
        evt = '0;
        wr(A_CTRL, 0);
        rd_chk($sformatf("R8 code 0x%02h", c), A_VAL, k);
        rd_chk("R5 type readback", A_TYPE, c);
      end
    end

    // R9 and R7: cycle code and cycle counter over one run
    n = 37;
    wr(A_SEL, 0); wr(A_TYPE, 32'h11); wr(A_VAL, 0);
    wr(A_CYC, 0);
    rd_chk("R7 zero write clears", A_CYC, 0);
    wr(A_CTRL, 1);
    idle(n);
    wr(A_CTRL, 0);
    rd_chk("R9 cycle code count", A_VAL, n + 2);
    rd_chk("R7 cyc count", A_CYC, n + 2);

    // R4: disabled event counter holds while others run
    wr(A_CLR, 1); wr(A_VAL, 0);
    wr(A_CTRL, 1); idle(5); wr(A_CTRL, 0);
    rd_chk("R4 masked counter holds", A_VAL, 0);
    rd_chk("R4 cyc still runs", A_CYC, n + 2 + 7);
    wr(A_SET, 1);

    // R2: pulse reset bits
    for (int j = 0; j < 3; j++) begin wr(A_SEL, j); wr(A_VAL, 7 + j); end
    wr(A_CTRL, 32'h2);
    for (int j = 0; j < 3; j++) begin
      wr(A_SEL, j);
      rd_chk($sformatf("R2 evt%0d cleared", j), A_VAL, 0);
    end
    rd_chk("R2 cyc untouched by evt clear", A_CYC, n + 2 + 7);
    wr(A_CTRL, 32'h4);
    rd_chk("R2 cyc cleared", A_CYC, 0);
    wr(A_CTRL, 32'hE);
    rd_chk("R2 pulse bits read 0", A_CTRL, 32'h8);
    wr(A_CTRL, 0);

    // R3: divide by 64
    wr(A_CTRL, 32'h4);
    wr(A_CTRL, 32'h9); idle(200); wr(A_CTRL, 32'h8);
    rd_chk("R3 div rate", A_CYC, 202 / 64);
    wr(A_CTRL, 32'hC);
    wr(A_CTRL, 32'h9); idle(60); wr(A_CTRL, 32'h8);
    rd_chk("R3 prescaler cleared", A_CYC, 62 / 64);
    wr(A_CTRL, 32'h9); wr(A_CTRL, 32'h8);
    rd_chk("R3 64th tick", A_CYC, 64 / 64);

    // R7: non-zero write ignored, zero clears
    wr(A_CYC, 32'h55);
    rd_chk("R7 nonzero ignored", A_CYC, 1);
    wr(A_CYC, 0);
    rd_chk("R7 zero clears", A_CYC, 0);
    wr(A_CTRL, 0);

    // R5: indirect type access per counter
    for (int j = 0; j < 3; j++) begin wr(A_SEL, j); wr(A_TYPE, 32'h21 + j); end
    wr(A_SEL, 0); wr(A_VAL, 32'h1234);
    for (int j = 0; j < 3; j++) begin
      wr(A_SEL, j);
      rd_chk("R5 sel readback", A_SEL, j);
      rd_chk("R5 indirect type", A_TYPE, 32'h21 + j);
    end

    // R6: out-of-range select
    for (int s = 3; s < 16; s += 4) begin
      wr(A_SEL, s);
      wr(A_TYPE, 32'h7F); wr(A_VAL, 32'hDEAD);
      rd_chk("R6 bad sel type", A_TYPE, 0);
      rd_chk("R6 bad sel val", A_VAL, 0);
    end
    for (int j = 0; j < 3; j++) begin
      wr(A_SEL, j);
      rd_chk("R6 type untouched", A_TYPE, 32'h21 + j);
      rd_chk("R6 val untouched", A_VAL, (j == 0) ? 32'h1234 : 0);
    end

    // R10: software increment
    wr(A_SEL, 0); wr(A_TYPE, 0); wr(A_VAL, 0);
    wr(A_SEL, 1); wr(A_TYPE, 0); wr(A_VAL, 0);
    wr(A_SEL, 2); wr(A_TYPE, 5); wr(A_VAL, 0);
    wr(A_INC, 7);
    wr(A_CTRL, 1);
    repeat (3) wr(A_INC, 7);
    repeat (2) wr(A_INC, 1);
    wr(A_CTRL, 0);
    wr(A_INC, 7);
    wr(A_SEL, 0); rd_chk("R10 evt0 sw inc", A_VAL, 5);
    wr(A_SEL, 1); rd_chk("R10 evt1 sw inc", A_VAL, 3);
    wr(A_SEL, 2); rd_chk("R10 non-sw code ignores", A_VAL, 0);

    // R11: wrap
    wr(A_SEL, 0); wr(A_VAL, 32'hFFFF_FFFE);
    wr(A_CTRL, 1);
    repeat (3) wr(A_INC, 1);
    wr(A_CTRL, 0);
    rd_chk("R11 wrap", A_VAL, 1);

    summary();
  end

endmodule